// File: doc/BRIEF.md
# Codec control frame writer

This block delivers one 16-bit control word to one of two codec devices over a write-only three-wire serial link. The link has a shared data line, a shared clock line, and an active-low select line for each device. A single-cycle start pulse hands over a chip index, a 5-bit register number and an 8-bit value. The block builds the word, runs the transfer at a pace set by a settle parameter, and then reports completion with a one-cycle done pulse.

The word is sent most significant bit first. Bit by bit, the clock is pulled low, the data line is changed, and the clock is raised. Every step is held for the settle time, so the device samples data on a clean rising edge. Before the first bit, all lines stay high for a settle time. After the last bit, all lines go high together and stay high for one more settle time. Chip indices that no device answers to are refused without touching the link, and a start that arrives during a transfer is dropped.

Top module: `ctl_frame_writer`

## Requirements
- R1: The word is shifted out most significant bit first. Bits 15..14 carry the chip address parameter CHIP_ADDR (default 2), bit 13 is a constant 1 write flag, bits 12..8 carry the register number and bits 7..0 carry the data byte. A bench that samples the data line on each rising clock edge therefore collects exactly this 16-bit word.
- R2: During and after reset, and whenever the block is idle, the data line, the clock line and both selects are high, and busy and done are low. A reset that arrives during a transfer returns the block to this state.
- R3: After a start is accepted, all lines stay high for exactly SETTLE clock cycles before a select drops.
- R4: Chip index 0 drives sel_n_o[0] low. Indices 1, 2 and 3 drive sel_n_o[1] low. At most one select is ever low.
- R5: Each bit takes three phases of SETTLE cycles each: clock low, then data update, then clock high. Data never changes while the clock is high and a select is low.
- R6: After the last bit, clock, data and select all return high in the same cycle and stay high for SETTLE cycles. The done pulse follows, exactly (3*16+3)*SETTLE cycles after the edge that accepted the start.
- R7: A start with a chip index of 4 or more is refused. Busy stays low, no line moves and no done pulse is produced.
- R8: A start pulse that arrives while busy is ignored. The word and the select in flight are unchanged.
- R9: Busy is high from the accepting edge until the cycle of the done pulse. Done lasts exactly one cycle, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a word |
| chip_idx_i | input | IDX_W (3) | Target device index; 0 selects device 0, 1..3 device 1, others refused |
| reg_addr_i | input | REG_W (5) | Register number placed in the word |
| data_i | input | DATA_W (8) | Data byte placed in the word |
| sdata_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock line; the device samples on its rising edge |
| sel_n_o | output | 2 | Active-low select, one bit per device |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that start_i, chip_idx_i, reg_addr_i and data_i are stable around the clock edge, and that start_i is a single-cycle request. No other timing is assumed for the inputs. The stimulus changes inputs only on falling edges and holds start for one cycle. It also raises a second start in the middle of a transfer on purpose, so the property that busy blocks new work is actually exercised and not left vacuous. Refused indices are applied only while the block is idle, because that is the only state in which the refusal property is defined.

// File: rtl/ctl_frame_pkg.sv
package ctl_frame_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SELECT,
        PH_CLK_LO,
        PH_DATA,
        PH_CLK_HI,
        PH_TAIL
    } phase_e;

    localparam int unsigned NUM_SEL = 2;

endpackage

// File: rtl/ctl_chip_decode.sv
module ctl_chip_decode #(
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned IDX_LIMIT = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             valid_o,
    output logic [1:0]       sel_oh_o
);
    // Index 0 reaches device 0; any other accepted index reaches device 1.
    always_comb begin
        valid_o  = (32'(idx_i) < IDX_LIMIT);
        sel_oh_o = (idx_i == '0) ? 2'b01 : 2'b10;
    end
endmodule

// File: rtl/ctl_frame_build.sv
module ctl_frame_build #(
    parameter int unsigned     CHIP_ADDR_W = 2,
    parameter logic [1:0]      CHIP_ADDR   = 2'd2,
    parameter int unsigned     REG_W       = 5,
    parameter int unsigned     DATA_W      = 8,
    localparam int unsigned    FRAME_W     = CHIP_ADDR_W + 1 + REG_W + DATA_W
) (
    input  logic [REG_W-1:0]   reg_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [FRAME_W-1:0] word_o
);
    // Address on top, write flag, register number, data in the low byte.
    always_comb begin
        word_o = {CHIP_ADDR[CHIP_ADDR_W-1:0], 1'b1, reg_i, data_i};
    end
endmodule

// File: rtl/ctl_settle_timer.sv
module ctl_settle_timer #(
    parameter int unsigned  SETTLE = 4,
    localparam int unsigned CNT_W  = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = clear_i ? '0 : cnt_q + CNT_W'(1);
        last_o = (cnt_q == CNT_W'(SETTLE - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ctl_frame_writer.sv
module ctl_frame_writer
    import ctl_frame_pkg::*;
#(
    parameter int unsigned SETTLE    = 4,
    parameter logic [1:0]  CHIP_ADDR = 2'd2,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned IDX_LIMIT = 4,
    parameter int unsigned REG_W     = 5,
    parameter int unsigned DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  chip_idx_i,
    input  logic [REG_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic [1:0]        sel_n_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned FRAME_W = 2 + 1 + REG_W + DATA_W;
    localparam int unsigned BIT_W   = $clog2(FRAME_W);

    typedef struct packed {
        phase_e             phase;
        logic [FRAME_W-1:0] frame;
        logic [BIT_W-1:0]   bit_idx;
        logic [1:0]         sel_pick;
        logic               sclk;
        logic               sdata;
        logic [1:0]         sel_n;
        logic               done;
    } st_t;

    st_t st_d, st_q;

    logic               idx_ok;
    logic [1:0]         sel_oh;
    logic [FRAME_W-1:0] word;
    logic               t_last;
    logic               t_clear;

    ctl_chip_decode #(.IDX_W(IDX_W), .IDX_LIMIT(IDX_LIMIT)) u_dec (
        .idx_i    (chip_idx_i),
        .valid_o  (idx_ok),
        .sel_oh_o (sel_oh)
    );

    ctl_frame_build #(.CHIP_ADDR(CHIP_ADDR), .REG_W(REG_W), .DATA_W(DATA_W)) u_build (
        .reg_i  (reg_addr_i),
        .data_i (data_i),
        .word_o (word)
    );

    ctl_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (t_clear),
        .last_o  (t_last)
    );

    // The timer restarts on every phase change and is held at zero while idle.
    assign t_clear = (st_q.phase == PH_IDLE) || t_last;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i && idx_ok) begin
                    st_d.phase    = PH_LEAD;
                    st_d.frame    = word;
                    st_d.sel_pick = sel_oh;
                end
            end
            PH_LEAD: if (t_last) begin
                st_d.phase = PH_SELECT;
                st_d.sel_n = ~st_q.sel_pick;
            end
            PH_SELECT: if (t_last) begin
                st_d.phase   = PH_CLK_LO;
                st_d.sclk    = 1'b0;
                st_d.bit_idx = BIT_W'(FRAME_W - 1);
            end
            PH_CLK_LO: if (t_last) begin
                st_d.phase = PH_DATA;
                st_d.sdata = st_q.frame[st_q.bit_idx];
            end
            PH_DATA: if (t_last) begin
                st_d.phase = PH_CLK_HI;
                st_d.sclk  = 1'b1;
            end
            PH_CLK_HI: if (t_last) begin
                if (st_q.bit_idx == '0) begin
                    st_d.phase = PH_TAIL;
                    st_d.sclk  = 1'b1;
                    st_d.sdata = 1'b1;
                    st_d.sel_n = 2'b11;
                end else begin
                    st_d.phase   = PH_CLK_LO;
                    st_d.sclk    = 1'b0;
                    st_d.bit_idx = st_q.bit_idx - BIT_W'(1);
                end
            end
            PH_TAIL: if (t_last) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.frame    <= '0;
            st_q.bit_idx  <= '0;
            st_q.sel_pick <= '0;
            st_q.sclk     <= 1'b1;
            st_q.sdata    <= 1'b1;
            st_q.sel_n    <= 2'b11;
            st_q.done     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.sdata;
    assign sclk_o  = st_q.sclk;
    assign sel_n_o = st_q.sel_n;
    assign busy_o  = (st_q.phase != PH_IDLE);
    assign done_o  = st_q.done;

endmodule

// File: rtl/ctl_frame_writer_chk.sv
module ctl_frame_writer_chk #(
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned IDX_LIMIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [IDX_W-1:0] chip_idx_i,
    input logic             sdata_o,
    input logic             sclk_o,
    input logic [1:0]       sel_n_o,
    input logic             busy_o,
    input logic             done_o
);
    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n_o));

    assert_idle_lines_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sclk_o && sdata_o && sel_n_o == 2'b11));

    assert_data_stable_clk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o) && sel_n_o != 2'b11 && $past(sel_n_o) != 2'b11)
            |-> $stable(sdata_o));

    assert_clock_falls_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (sel_n_o != 2'b11));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    assert_bad_index_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && 32'(chip_idx_i) >= IDX_LIMIT) |=> !busy_o);

    assert_tail_all_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n_o[0] & sel_n_o[1]) |-> (sclk_o && sdata_o && busy_o));
endmodule

bind ctl_frame_writer ctl_frame_writer_chk #(.IDX_W(IDX_W), .IDX_LIMIT(IDX_LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .chip_idx_i (chip_idx_i),
    .sdata_o    (sdata_o),
    .sclk_o     (sclk_o),
    .sel_n_o    (sel_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/sim_ctl_frame_writer.sv
module sim_ctl_frame_writer;
    localparam int SET = 3;
    localparam int LAT = (3 * 16 + 3) * SET;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] idx = '0;
    logic [4:0] ra = '0;
    logic [7:0] dat = '0;
    logic       w_sdata, w_sclk, w_busy, w_done;
    logic [1:0] w_sel_n;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] cap;
    int          nbits;
    logic [1:0]  selseen;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    ctl_frame_writer #(.SETTLE(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chip_idx_i(idx),
        .reg_addr_i(ra), .data_i(dat), .sdata_o(w_sdata), .sclk_o(w_sclk),
        .sel_n_o(w_sel_n), .busy_o(w_busy), .done_o(w_done)
    );

    // Bits the device would see on each rising clock edge while selected.
    always @(posedge w_sclk) begin
        if (rst_n && w_sel_n != 2'b11) begin
            cap     = {cap[14:0], w_sdata};
            nbits   = nbits + 1;
            selseen = w_sel_n;
        end
    end

    // {index[2:0], register[4:0], data[7:0]}
    localparam logic [15:0] VEC [0:5] = '{
        {3'd0, 5'h00, 8'h00},
        {3'd1, 5'h1F, 8'hFF},
        {3'd2, 5'h0A, 8'hA5},
        {3'd3, 5'h15, 8'h5A},
        {3'd0, 5'h02, 8'h81},
        {3'd1, 5'h03, 8'h7E}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [2:0] i, input logic [4:0] r, input logic [7:0] d,
                        input bit inject, output int lead, output int lat);
        int cyc;
        cap = '0; nbits = 0; selseen = 2'b11;
        lead = -1; lat = -1; cyc = 0;
        @(negedge clk);
        start = 1'b1; idx = i; ra = r; dat = d;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 40) begin
                start = 1'b1; idx = (i == 3'd0) ? 3'd1 : 3'd0; ra = ~r; dat = ~d;
            end else begin
                start = 1'b0;
            end
            if (lead < 0 && w_sel_n != 2'b11) lead = cyc - 1;
            if (w_done) begin
                lat = cyc - 1;
                chk(!w_busy, "R9 busy low in done cycle", 32'(w_busy), 32'd0);
                break;
            end
        end
        @(negedge clk);
        chk(!w_done, "R9 done lasts one cycle", 32'(w_done), 32'd0);
        chk(w_sclk && w_sdata && w_sel_n == 2'b11, "R2 lines high after transfer",
            {29'd0, w_sclk, w_sel_n}, 32'h7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int lead, lat;
        logic [15:0] exp_w;
        logic [1:0]  exp_s;
        bit quiet;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(w_sclk && w_sdata && w_sel_n == 2'b11 && !w_busy && !w_done,
            "R2 reset state", {27'd0, w_sclk, w_sdata, w_sel_n, w_busy}, 32'h1E);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 6; k++) begin
            logic [2:0] vi;
            logic [4:0] vr;
            logic [7:0] vd;
            {vi, vr, vd} = VEC[k];
            exp_w = {2'b10, 1'b1, vr, vd};
            exp_s = (vi == 3'd0) ? 2'b10 : 2'b01;
            xfer(vi, vr, vd, 1'b0, lead, lat);
            chk(cap == exp_w && nbits == 16, "R1 captured word", {cap, 16'(nbits)}, {exp_w, 16'd16});
            chk(selseen == exp_s, "R4 select mapping", 32'(selseen), 32'(exp_s));
            chk(lead == SET, "R3 lead time", 32'(lead), 32'(SET));
            chk(lat == LAT, "R6 done latency", 32'(lat), 32'(LAT));
        end

        // R8: a start arriving mid-transfer is dropped
        xfer(3'd2, 5'h11, 8'h3C, 1'b1, lead, lat);
        chk(cap == {2'b10, 1'b1, 5'h11, 8'h3C} && nbits == 16, "R8 word unchanged by busy start",
            {cap, 16'(nbits)}, {16'h B13C, 16'd16});
        chk(selseen == 2'b01, "R8 select unchanged by busy start", 32'(selseen), 32'h1);
        chk(lat == LAT, "R8 timing unchanged by busy start", 32'(lat), 32'(LAT));
        repeat (2) @(negedge clk);
        chk(!w_busy, "R8 no queued transfer", 32'(w_busy), 32'd0);

        // R7: out-of-range indices refused
        for (int bi = 4; bi < 8; bi++) begin
            nbits = 0;
            quiet = 1'b1;
            @(negedge clk);
            start = 1'b1; idx = 3'(bi); ra = 5'h1F; dat = 8'hFF;
            @(negedge clk);
            start = 1'b0;
            repeat (12) begin
                if (w_busy || w_done || !w_sclk || w_sel_n != 2'b11) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet && nbits == 0, "R7 bad index refused", {31'd0, quiet}, 32'd1);
        end

        // R2: reset in the middle of a transfer
        @(negedge clk);
        start = 1'b1; idx = 3'd1; ra = 5'h05; dat = 8'h0F;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(w_busy, "R9 busy during transfer", 32'(w_busy), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(w_sclk && w_sdata && w_sel_n == 2'b11 && !w_busy, "R2 reset mid-transfer",
            {28'd0, w_sclk, w_sdata, w_sel_n}, 32'hF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5: fresh transfer after reset still produces the correct word
        xfer(3'd0, 5'h1E, 8'h96, 1'b0, lead, lat);
        chk(cap == {2'b10, 1'b1, 5'h1E, 8'h96} && nbits == 16, "R5 bit sequence after reset",
            {cap, 16'(nbits)}, {16'hBE96, 16'd16});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule